// File: doc/BRIEF.md
# Load/Store Watchpoint Event Combiner

This block turns raw match bits from a debug unit's comparators into load/store watchpoint pulses. Its inputs are the instruction watchpoint events, the hit bits of two load/store address comparators (E and F), and per-byte-lane hit bits from two data comparators (G and H). Each watchpoint output has its own three-field setting. One field picks an instruction watchpoint or skips that term. One picks an address combination. One picks a data combination.

For each output, the three chosen terms and a strobe are ANDed together. The strobe marks a valid load/store access in the current cycle. The result is registered, so each output gives a one-cycle pulse one clock after the access. A term that is skipped counts as true. When every term is skipped, the output still fires only on a load/store access, because the strobe is always part of the AND. For the data AND combination, the G and H hits are paired within each byte lane first, and only then are the lanes ORed. A G hit in one lane and an H hit in a different lane therefore do not satisfy it.

Top module: `ldw_combiner`

## Requirements
- R1: While rst_n is sampled low at a rising clock edge, wp_out is 0 after that edge.
- R2: wp_out[k] changes only at a rising edge. It reflects the inputs and configuration sampled at that edge, so the latency is one cycle.
- R3: Instruction select field (3 bits per watchpoint). Codes 0 to 3 choose iw_evt[code]. Code 4 skips the instruction term.
- R4: Address select field (3 bits). 0 = E, 1 = F, 2 = E AND F, 3 = E OR F, 4 = skip.
- R5: Data select codes 0 and 1 use G and H respectively. G is the OR of all data_g_lane bits, and H is the OR of all data_h_lane bits.
- R6: Data select code 2 is true only if some lane i has both data_g_lane[i] and data_h_lane[i] set.
- R7: Data select code 3 is true if any of the G or H lane bits is set. Data code 4 skips the data term.
- R8: A skipped term counts as 1. With all three fields at 4, wp_out[k] follows ls_valid alone.
- R9: When ls_valid is 0, no watchpoint fires, whatever the other inputs are.
- R10: Codes 5 to 7 in any field make that watchpoint never fire.
- R11: Each watchpoint uses only its own 3-bit slice of each config port, at bits [3k+2:3k]. On the same access, one watchpoint can fire while the other does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iw_evt | input | 4 | Instruction watchpoint events |
| addr_e_hit | input | 1 | Address comparator E match |
| addr_f_hit | input | 1 | Address comparator F match |
| data_g_lane | input | 4 | Data comparator G match, one bit per byte lane |
| data_h_lane | input | 4 | Data comparator H match, one bit per byte lane |
| ls_valid | input | 1 | Valid load/store access this cycle |
| cfg_isel | input | 6 | Instruction select, 3 bits per watchpoint |
| cfg_asel | input | 6 | Address select, 3 bits per watchpoint |
| cfg_dsel | input | 6 | Data select, 3 bits per watchpoint |
| wp_out | output | 2 | Registered watchpoint pulses |

## Verification
Both watchpoints evaluate the same access in the same cycle. The stimulus table therefore sets the two configurations differently on every row and checks both output bits at once. Some rows expect one watchpoint to fire and the other to stay low. Others expect both to fire, or neither. The other overlap is between the lane-wise AND and the lane-wide OR of the data hits. One row places G and H hits in different lanes, so that one watchpoint using the AND stays low while a watchpoint using the OR fires.

// File: rtl/ldw_pkg.sv
// Shared select encodings for the load/store watchpoint combiner.
package ldw_pkg;
    localparam int SEL_W = 3;
    // Pair-select codes, used for both the address field and the data field.
    localparam logic [SEL_W-1:0] PSEL_A      = 3'd0;
    localparam logic [SEL_W-1:0] PSEL_B      = 3'd1;
    localparam logic [SEL_W-1:0] PSEL_AND    = 3'd2;
    localparam logic [SEL_W-1:0] PSEL_OR     = 3'd3;
    // Skip code, shared by all three fields.
    localparam logic [SEL_W-1:0] SEL_SKIP    = 3'd4;
endpackage

// File: rtl/ldw_lane_reduce.sv
// Reduces the per-lane data comparator hits to the four data terms.
// Assumes lane i of G pairs with lane i of H.
module ldw_lane_reduce #(
    parameter int NUM_LANES = 4
) (
    input  logic [NUM_LANES-1:0] g_lane,
    input  logic [NUM_LANES-1:0] h_lane,
    output logic                 g_any,
    output logic                 h_any,
    output logic                 gh_lane_and,
    output logic                 gh_any
);
    // Lane-wise pairing happens before the OR over lanes.
    always_comb begin
        g_any       = |g_lane;
        h_any       = |h_lane;
        gh_lane_and = |(g_lane & h_lane);
        gh_any      = g_any | h_any;
    end
endmodule

// File: rtl/ldw_pair_select.sv
// Five-way selector for a pair of comparators (A, B, A&B, A|B, skip).
// Codes above the skip code give 0 (never match).
module ldw_pair_select
    import ldw_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             a_hit,
    input  logic             b_hit,
    input  logic             both_hit,
    input  logic             either_hit,
    output logic             term
);
    // Pick the combined comparator term.
    always_comb begin
        unique case (sel)
            PSEL_A:   term = a_hit;
            PSEL_B:   term = b_hit;
            PSEL_AND: term = both_hit;
            PSEL_OR:  term = either_hit;
            SEL_SKIP: term = 1'b1;
            default:  term = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldw_inst_select.sv
// Picks one instruction watchpoint event, or skips the term.
// Assumes NUM_IW does not exceed the skip code.
module ldw_inst_select
    import ldw_pkg::*;
#(
    parameter int NUM_IW = 4
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_IW-1:0] iw_evt,
    output logic              term
);
    // Index the chosen event. Skip gives 1 and unused codes give 0.
    always_comb begin
        term = (sel == SEL_SKIP);
        for (int k = 0; k < NUM_IW; k++) begin
            if (sel == SEL_W'(k)) term = iw_evt[k];
        end
    end
endmodule

// File: rtl/ldw_channel.sv
// One watchpoint: selects three terms, ANDs them with the access
// strobe, and registers the result.
module ldw_channel
    import ldw_pkg::*;
#(
    parameter int NUM_IW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IW-1:0] iw_evt,
    input  logic              e_hit,
    input  logic              f_hit,
    input  logic              g_any,
    input  logic              h_any,
    input  logic              gh_lane_and,
    input  logic              gh_any,
    input  logic              ls_valid,
    input  logic [SEL_W-1:0]  isel,
    input  logic [SEL_W-1:0]  asel,
    input  logic [SEL_W-1:0]  dsel,
    output logic              wp
);
    logic i_term, a_term, d_term;

    ldw_inst_select #(.NUM_IW(NUM_IW)) u_isel (
        .sel(isel), .iw_evt(iw_evt), .term(i_term)
    );

    ldw_pair_select u_asel (
        .sel(asel), .a_hit(e_hit), .b_hit(f_hit),
        .both_hit(e_hit & f_hit), .either_hit(e_hit | f_hit), .term(a_term)
    );

    ldw_pair_select u_dsel (
        .sel(dsel), .a_hit(g_any), .b_hit(h_any),
        .both_hit(gh_lane_and), .either_hit(gh_any), .term(d_term)
    );

    // Register the gated watchpoint pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) wp <= 1'b0;
        else        wp <= ls_valid & i_term & a_term & d_term;
    end
endmodule

// File: rtl/ldw_combiner.sv
// Top: shares one lane reducer and builds NUM_WP independent
// watchpoint channels. Config ports are packed with channel k at
// bits [SEL_W*k +: SEL_W].
module ldw_combiner
    import ldw_pkg::*;
#(
    parameter int NUM_IW    = 4,
    parameter int NUM_LANES = 4,
    parameter int NUM_WP    = 2,
    localparam int CFG_W    = NUM_WP * SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IW-1:0]    iw_evt,
    input  logic                 addr_e_hit,
    input  logic                 addr_f_hit,
    input  logic [NUM_LANES-1:0] data_g_lane,
    input  logic [NUM_LANES-1:0] data_h_lane,
    input  logic                 ls_valid,
    input  logic [CFG_W-1:0]     cfg_isel,
    input  logic [CFG_W-1:0]     cfg_asel,
    input  logic [CFG_W-1:0]     cfg_dsel,
    output logic [NUM_WP-1:0]    wp_out
);
    logic g_any, h_any, gh_lane_and, gh_any;

    ldw_lane_reduce #(.NUM_LANES(NUM_LANES)) u_lanes (
        .g_lane(data_g_lane), .h_lane(data_h_lane),
        .g_any(g_any), .h_any(h_any),
        .gh_lane_and(gh_lane_and), .gh_any(gh_any)
    );

    for (genvar k = 0; k < NUM_WP; k++) begin : g_wp
        ldw_channel #(.NUM_IW(NUM_IW)) u_ch (
            .clk(clk), .rst_n(rst_n), .iw_evt(iw_evt),
            .e_hit(addr_e_hit), .f_hit(addr_f_hit),
            .g_any(g_any), .h_any(h_any),
            .gh_lane_and(gh_lane_and), .gh_any(gh_any),
            .ls_valid(ls_valid),
            .isel(cfg_isel[k*SEL_W +: SEL_W]),
            .asel(cfg_asel[k*SEL_W +: SEL_W]),
            .dsel(cfg_dsel[k*SEL_W +: SEL_W]),
            .wp(wp_out[k])
        );
    end
endmodule

// File: rtl/ldw_checker.sv
// Property checks for ldw_combiner, attached to it with bind.
module ldw_checker
    import ldw_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int NUM_WP    = 2,
    localparam int CFG_W    = NUM_WP * SEL_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LANES-1:0] data_g_lane,
    input logic [NUM_LANES-1:0] data_h_lane,
    input logic                 ls_valid,
    input logic [CFG_W-1:0]     cfg_isel,
    input logic [CFG_W-1:0]     cfg_asel,
    input logic [CFG_W-1:0]     cfg_dsel,
    input logic [NUM_WP-1:0]    wp_out
);
    for (genvar k = 0; k < NUM_WP; k++) begin : g_chk
        // R9: no access strobe, no pulse on the next edge.
        a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            !ls_valid |=> !wp_out[k]);
        // R10: reserved data or address codes never fire.
        a_r10_bad_data: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_dsel[k*SEL_W +: SEL_W] > SEL_SKIP) |=> !wp_out[k]);
        a_r10_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_asel[k*SEL_W +: SEL_W] > SEL_SKIP) |=> !wp_out[k]);
        // R8: all terms skipped, the strobe alone fires.
        a_r8_all_skip: assert property (@(posedge clk) disable iff (!rst_n)
            (ls_valid && cfg_isel[k*SEL_W +: SEL_W] == SEL_SKIP
                      && cfg_asel[k*SEL_W +: SEL_W] == SEL_SKIP
                      && cfg_dsel[k*SEL_W +: SEL_W] == SEL_SKIP) |=> wp_out[k]);
        // R6: the lane-wise AND needs a lane with both hits.
        a_r6_lane_pair: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_dsel[k*SEL_W +: SEL_W] == PSEL_AND
                && (data_g_lane & data_h_lane) == '0) |=> !wp_out[k]);
        // R5: data G selected with no G lane hit never fires.
        a_r5_g_none: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_dsel[k*SEL_W +: SEL_W] == PSEL_A && data_g_lane == '0)
                |=> !wp_out[k]);
    end
endmodule

bind ldw_combiner ldw_checker #(.NUM_LANES(NUM_LANES), .NUM_WP(NUM_WP)) u_ldw_chk (
    .clk(clk), .rst_n(rst_n), .data_g_lane(data_g_lane),
    .data_h_lane(data_h_lane), .ls_valid(ls_valid),
    .cfg_isel(cfg_isel), .cfg_asel(cfg_asel), .cfg_dsel(cfg_dsel),
    .wp_out(wp_out)
);

// File: tb/test_ldw_combiner.sv
`timescale 1ns/1ps
module test_ldw_combiner;
    typedef struct packed {
        logic [3:0] iw;
        logic       e, f;
        logic [3:0] g, h;
        logic       v;
        logic [2:0] i0, a0, d0, i1, a1, d1;
        logic [1:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        {4'b0001,1'b1,1'b0,4'b0000,4'b0000,1'b1,3'd0,3'd0,3'd4,3'd1,3'd0,3'd4,2'b01},
        {4'b0100,1'b0,1'b1,4'b0000,4'b0000,1'b1,3'd2,3'd1,3'd4,3'd2,3'd0,3'd4,2'b01},
        {4'b0000,1'b1,1'b0,4'b0000,4'b0000,1'b1,3'd4,3'd2,3'd4,3'd4,3'd3,3'd4,2'b10},
        {4'b0000,1'b1,1'b1,4'b0000,4'b0000,1'b1,3'd4,3'd2,3'd4,3'd4,3'd4,3'd4,2'b11},
        {4'b0000,1'b0,1'b0,4'b0010,4'b0000,1'b1,3'd4,3'd4,3'd0,3'd4,3'd4,3'd1,2'b01},
        {4'b0000,1'b0,1'b0,4'b0000,4'b1000,1'b1,3'd4,3'd4,3'd0,3'd4,3'd4,3'd1,2'b10},
        {4'b0000,1'b0,1'b0,4'b0001,4'b0010,1'b1,3'd4,3'd4,3'd2,3'd4,3'd4,3'd3,2'b10},
        {4'b0000,1'b0,1'b0,4'b0110,4'b0100,1'b1,3'd4,3'd4,3'd2,3'd4,3'd4,3'd3,2'b11},
        {4'b0000,1'b0,1'b0,4'b0000,4'b0000,1'b1,3'd4,3'd4,3'd3,3'd4,3'd4,3'd4,2'b10},
        {4'b1111,1'b1,1'b1,4'b1111,4'b1111,1'b0,3'd4,3'd4,3'd4,3'd0,3'd0,3'd0,2'b00},
        {4'b1111,1'b1,1'b1,4'b1111,4'b1111,1'b1,3'd5,3'd4,3'd4,3'd4,3'd6,3'd4,2'b00},
        {4'b1111,1'b1,1'b1,4'b1111,4'b1111,1'b1,3'd4,3'd4,3'd5,3'd4,3'd4,3'd7,2'b00},
        {4'b1111,1'b1,1'b1,4'b1111,4'b1111,1'b1,3'd3,3'd3,3'd3,3'd4,3'd4,3'd4,2'b11},
        {4'b1000,1'b0,1'b1,4'b0001,4'b0001,1'b1,3'd3,3'd1,3'd2,3'd3,3'd0,3'd2,2'b01},
        {4'b0000,1'b0,1'b0,4'b0000,4'b0000,1'b1,3'd4,3'd4,3'd4,3'd7,3'd4,3'd4,2'b01}
    };
    localparam string TAG [NV] = '{"R3","R4","R4","R8","R5","R5","R6","R6",
                                   "R7","R9","R10","R10","R8","R11","R11"};

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] iw_evt, data_g_lane, data_h_lane;
    logic       addr_e_hit, addr_f_hit, ls_valid;
    logic [5:0] cfg_isel, cfg_asel, cfg_dsel;
    logic [1:0] wp_out;
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ldw_combiner i_ldw_combiner (
        .clk(clk), .rst_n(rst_n), .iw_evt(iw_evt),
        .addr_e_hit(addr_e_hit), .addr_f_hit(addr_f_hit),
        .data_g_lane(data_g_lane), .data_h_lane(data_h_lane),
        .ls_valid(ls_valid), .cfg_isel(cfg_isel), .cfg_asel(cfg_asel),
        .cfg_dsel(cfg_dsel), .wp_out(wp_out)
    );

    task automatic apply(input vec_t x);
        iw_evt = x.iw; addr_e_hit = x.e; addr_f_hit = x.f;
        data_g_lane = x.g; data_h_lane = x.h; ls_valid = x.v;
        cfg_isel = {x.i1, x.i0}; cfg_asel = {x.a1, x.a0}; cfg_dsel = {x.d1, x.d0};
    endtask

    task automatic check(input string req, input logic [1:0] exp);
        total++;
        if (wp_out !== exp) begin
            bad++;
            $display("FAIL %s: wp_out=%b expected=%b", req, wp_out, exp);
        end
    endtask

    // All-skip on both channels with a valid access: fires when out of reset.
    localparam vec_t FIRE = {4'b0000,1'b0,1'b0,4'b0000,4'b0000,1'b1,
                             3'd4,3'd4,3'd4,3'd4,3'd4,3'd4,2'b11};
    localparam vec_t IDLE = {4'b0000,1'b0,1'b0,4'b0000,4'b0000,1'b0,
                             3'd4,3'd4,3'd4,3'd4,3'd4,3'd4,2'b00};

    initial begin
        rst_n = 1'b0;
        apply(FIRE);
        repeat (3) @(negedge clk);
        check("R1", 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", 2'b11);

        // Table walk: apply at a falling edge, check at the next falling edge.
        for (int n = 0; n < NV; n++) begin
            apply(VEC[n]);
            @(negedge clk);
            check(TAG[n], VEC[n].exp);
        end

        // R2: the output holds until the rising edge that samples the new input.
        apply(IDLE);
        @(negedge clk);
        check("R9", 2'b00);
        apply(FIRE);
        #1;
        check("R2", 2'b00);
        @(negedge clk);
        check("R2", 2'b11);

        // R1: reset taken mid-stream clears the pulse.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 2'b00);
        rst_n = 1'b1;
        apply(IDLE);
        @(negedge clk);
        check("R9", 2'b00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule